// File: doc/BRIEF.md
# Cycle and Retirement Performance Counters

This block keeps two 64-bit event counters for a processor core. One counts core clock cycles while the core reports that it is executing. The other counts instructions that complete. Software reaches each counter as two 32-bit halves through a control-register read/write port. A separate inhibit register lets software stop either counter on its own, which saves the switching power of a counter nobody is reading.

The port carries a request strobe, a write enable, a 12-bit register address and 32-bit write data. Read data and an illegal-access flag come back combinationally in the same cycle as the request. Reads return the register contents as they stood at the start of that cycle. Writes and increments take effect at the next clock edge. Address decoding for the wider register space, privilege checks and the pipeline sit outside this block.

Top module: `perf_ctr_unit`

## Requirements
- R1: The cycle counter increases by exactly 1 at each clock edge where `run_i` is 1 and inhibit bit 0 is 0, and holds its value when `run_i` is 0.
- R2: The retirement counter increases by exactly 1 at each clock edge where `retire_i` is 1 and inhibit bit 2 is 0, and holds its value otherwise.
- R3: Register addresses: cycle low word 0xB00, cycle high word 0xB80, retirement low word 0xB02, retirement high word 0xB82, inhibit register 0x320. A read returns the addressed value in the cycle of the request, as it stood before that cycle's clock edge.
- R4: After reset, both counters and the inhibit register read as 0. Counting starts in the first cycle after reset is released.
- R5: A set inhibit bit freezes only its own counter. The other counter keeps counting.
- R6: The inhibit register stores only bits 0 and 2 of the written data. All other bits read as 0. A new inhibit value acts from the clock edge after the write.
- R7: A write to one half of a counter replaces that half with the write data and leaves the other half unchanged.
- R8: A write to either half of a counter cancels that counter's increment in the same cycle.
- R9: An increment of a low word that holds 0xFFFFFFFF wraps it to 0 and adds 1 to the high word at the same clock edge.
- R10: A request to any address other than the five in R3 returns read data 0 and raises `csr_illegal_o` in the same cycle. A write to such an address changes no register. `csr_illegal_o` is 0 whenever `csr_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Core is executing this cycle |
| retire_i | input | 1 | One instruction completed this cycle |
| csr_req_i | input | 1 | Register access request |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, valid in the request cycle |
| csr_illegal_o | output | 1 | Request hit an unimplemented address |

## Verification
Any wrong value in a counter or in the inhibit register shows on the read port in the next cycle that reads that address. Because the bench reads some register almost every cycle and compares it with a running model, a lost carry, a missed or doubled increment, or a wrongly kept inhibit bit appears within a few cycles of the edge that caused it. A write that lands in the wrong half, or an increment that is not cancelled, shows in the first read of the affected word after the write.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned NUM_CTR     = 2;
    localparam int unsigned INH_W       = 3;
    localparam int unsigned CYC_INH_BIT = 0;
    localparam int unsigned RET_INH_BIT = 2;

    localparam logic [ADDR_W-1:0] ADDR_CYC_LO = 12'hB00;
    localparam logic [ADDR_W-1:0] ADDR_CYC_HI = 12'hB80;
    localparam logic [ADDR_W-1:0] ADDR_RET_LO = 12'hB02;
    localparam logic [ADDR_W-1:0] ADDR_RET_HI = 12'hB82;
    localparam logic [ADDR_W-1:0] ADDR_INH    = 12'h320;

    // Only the two control bits are stored; other positions read as zero.
    localparam logic [INH_W-1:0] INH_KEEP =
        INH_W'((1 << CYC_INH_BIT) | (1 << RET_INH_BIT));

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI,
        SEL_INH
    } reg_sel_e;

    typedef struct packed {
        logic [INH_W-1:0] mask;
    } inh_state_t;

endpackage

// File: rtl/perf_ctr_decode.sv
module perf_ctr_decode
    import perf_ctr_pkg::*;
(
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic              hit_o
);

    always_comb begin
        sel_o = SEL_NONE;
        if (req_i) begin
            unique case (addr_i)
                ADDR_CYC_LO: sel_o = SEL_CYC_LO;
                ADDR_CYC_HI: sel_o = SEL_CYC_HI;
                ADDR_RET_LO: sel_o = SEL_RET_LO;
                ADDR_RET_HI: sel_o = SEL_RET_HI;
                ADDR_INH:    sel_o = SEL_INH;
                default:     sel_o = SEL_NONE;
            endcase
        end
        hit_o = (sel_o != SEL_NONE);
    end

endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } slice_state_t;

    localparam logic [W-1:0] LO_ONE = W'(1);

    slice_state_t st_d, st_q;
    logic         lo_full;

    always_comb begin
        st_d    = st_q;
        lo_full = &st_q.lo;
        if (wr_lo_i) begin
            st_d.lo = wdata_i;
        end else if (wr_hi_i) begin
            st_d.hi = wdata_i;
        end else if (inc_i) begin
            st_d.lo = st_q.lo + LO_ONE;
            if (lo_full) begin
                st_d.hi = st_q.hi + LO_ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_o = st_q.lo;
    assign hi_o = st_q.hi;

endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
    import perf_ctr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              retire_i,
    input  logic              csr_req_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [WORD_W-1:0] csr_wdata_i,
    output logic [WORD_W-1:0] csr_rdata_o,
    output logic              csr_illegal_o
);

    reg_sel_e              sel;
    logic                  hit;
    logic                  wr_en;
    logic [NUM_CTR-1:0]    ev;
    logic [NUM_CTR-1:0]    ctr_inc;
    logic [NUM_CTR-1:0]    ctr_wr_lo;
    logic [NUM_CTR-1:0]    ctr_wr_hi;
    logic [WORD_W-1:0]     ctr_lo [NUM_CTR];
    logic [WORD_W-1:0]     ctr_hi [NUM_CTR];
    inh_state_t            inh_d, inh_q;

    // Observation points for the bound checker.
    logic [2*WORD_W-1:0]   cyc_val;
    logic [2*WORD_W-1:0]   ret_val;
    logic                  cyc_wr;
    logic                  ret_wr;

    perf_ctr_decode u_dec (
        .req_i  (csr_req_i),
        .addr_i (csr_addr_i),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    assign wr_en = csr_req_i & csr_we_i;

    always_comb begin
        ctr_wr_lo    = '0;
        ctr_wr_hi    = '0;
        ctr_wr_lo[0] = wr_en && (sel == SEL_CYC_LO);
        ctr_wr_hi[0] = wr_en && (sel == SEL_CYC_HI);
        ctr_wr_lo[1] = wr_en && (sel == SEL_RET_LO);
        ctr_wr_hi[1] = wr_en && (sel == SEL_RET_HI);
    end

    assign ev[0] = run_i;
    assign ev[1] = retire_i;

    always_comb begin
        inh_d = inh_q;
        if (wr_en && (sel == SEL_INH)) begin
            inh_d.mask = csr_wdata_i[INH_W-1:0] & INH_KEEP;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            inh_q <= '0;
        end else begin
            inh_q <= inh_d;
        end
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        localparam int unsigned STOP_BIT = (g == 0) ? CYC_INH_BIT : RET_INH_BIT;

        assign ctr_inc[g] = ev[g] & ~inh_q.mask[STOP_BIT];

        perf_ctr_slice #(
            .W (WORD_W)
        ) u_slice (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .inc_i   (ctr_inc[g]),
            .wr_lo_i (ctr_wr_lo[g]),
            .wr_hi_i (ctr_wr_hi[g]),
            .wdata_i (csr_wdata_i),
            .lo_o    (ctr_lo[g]),
            .hi_o    (ctr_hi[g])
        );
    end

    always_comb begin
        csr_rdata_o = '0;
        unique case (sel)
            SEL_CYC_LO: csr_rdata_o = ctr_lo[0];
            SEL_CYC_HI: csr_rdata_o = ctr_hi[0];
            SEL_RET_LO: csr_rdata_o = ctr_lo[1];
            SEL_RET_HI: csr_rdata_o = ctr_hi[1];
            SEL_INH:    csr_rdata_o = {{(WORD_W-INH_W){1'b0}}, inh_q.mask};
            default:    csr_rdata_o = '0;
        endcase
    end

    assign csr_illegal_o = csr_req_i & ~hit;

    assign cyc_val = {ctr_hi[0], ctr_lo[0]};
    assign ret_val = {ctr_hi[1], ctr_lo[1]};
    assign cyc_wr  = ctr_wr_lo[0] | ctr_wr_hi[0];
    assign ret_wr  = ctr_wr_lo[1] | ctr_wr_hi[1];

endmodule

// File: rtl/perf_ctr_checker.sv
module perf_ctr_checker
    import perf_ctr_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                run_i,
    input logic                retire_i,
    input logic                csr_req_i,
    input logic                csr_we_i,
    input logic [ADDR_W-1:0]   csr_addr_i,
    input logic [WORD_W-1:0]   csr_wdata_i,
    input logic [WORD_W-1:0]   csr_rdata_o,
    input logic                csr_illegal_o,
    input logic [INH_W-1:0]    inh_mask,
    input logic [2*WORD_W-1:0] cyc_val,
    input logic [2*WORD_W-1:0] ret_val,
    input logic                cyc_wr,
    input logic                ret_wr
);

    localparam logic [2*WORD_W-1:0] ONE64 = (2*WORD_W)'(1);

    a_r1_cyc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !inh_mask[CYC_INH_BIT] && !cyc_wr) |=> (cyc_val == $past(cyc_val) + ONE64));

    a_r1_cyc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !cyc_wr) |=> $stable(cyc_val));

    a_r2_ret_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_i && !inh_mask[RET_INH_BIT] && !ret_wr) |=> (ret_val == $past(ret_val) + ONE64));

    a_r2_ret_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!retire_i && !ret_wr) |=> $stable(ret_val));

    a_r5_cyc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inh_mask[CYC_INH_BIT] && !cyc_wr) |=> $stable(cyc_val));

    a_r5_ret_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inh_mask[RET_INH_BIT] && !ret_wr) |=> $stable(ret_val));

    a_r6_unused_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inh_mask[1]);

    a_r7_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_we_i && csr_addr_i == ADDR_CYC_LO) |=>
        (cyc_val[WORD_W-1:0] == $past(csr_wdata_i)) &&
        (cyc_val[2*WORD_W-1:WORD_W] == $past(cyc_val[2*WORD_W-1:WORD_W])));

    a_r8_hi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_we_i && csr_addr_i == ADDR_RET_HI) |=>
        (ret_val[2*WORD_W-1:WORD_W] == $past(csr_wdata_i)) &&
        (ret_val[WORD_W-1:0] == $past(ret_val[WORD_W-1:0])));

    a_r10_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> (csr_rdata_o == '0));

    a_r10_idle_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_req_i |-> !csr_illegal_o);

endmodule

bind perf_ctr_unit perf_ctr_checker u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run_i),
    .retire_i      (retire_i),
    .csr_req_i     (csr_req_i),
    .csr_we_i      (csr_we_i),
    .csr_addr_i    (csr_addr_i),
    .csr_wdata_i   (csr_wdata_i),
    .csr_rdata_o   (csr_rdata_o),
    .csr_illegal_o (csr_illegal_o),
    .inh_mask      (inh_q.mask),
    .cyc_val       (cyc_val),
    .ret_val       (ret_val),
    .cyc_wr        (cyc_wr),
    .ret_wr        (ret_wr)
);

// File: tb/perf_ctr_unit_bench.sv
`timescale 1ns/1ps
module perf_ctr_unit_bench;

    localparam logic [11:0] A_CL  = 12'hB00;
    localparam logic [11:0] A_CH  = 12'hB80;
    localparam logic [11:0] A_RL  = 12'hB02;
    localparam logic [11:0] A_RH  = 12'hB82;
    localparam logic [11:0] A_INH = 12'h320;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run, retire, req, we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        illegal;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 0;

    // Reference model state
    logic [63:0] m_cyc;
    logic [63:0] m_ret;
    logic [2:0]  m_inh;

    always #2.5 clk = ~clk;

    perf_ctr_unit u_perf_ctr_unit (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .run_i         (run),
        .retire_i      (retire),
        .csr_req_i     (req),
        .csr_we_i      (we),
        .csr_addr_i    (addr),
        .csr_wdata_i   (wdata),
        .csr_rdata_o   (rdata),
        .csr_illegal_o (illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic model_legal(input logic [11:0] a);
        return (a == A_CL) || (a == A_CH) || (a == A_RL) || (a == A_RH) || (a == A_INH);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            A_CL:    return m_cyc[31:0];
            A_CH:    return m_cyc[63:32];
            A_RL:    return m_ret[31:0];
            A_RH:    return m_ret[63:32];
            A_INH:   return {29'd0, m_inh};
            default: return 32'd0;
        endcase
    endfunction

    // One clock cycle: drive after the falling edge, compare before the rising edge,
    // then advance the model by what the rising edge should do.
    task automatic step(input logic r, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic rn, input logic rt,
                        input string tag);
        logic cyc_w, ret_w, cyc_go, ret_go;
        @(negedge clk);
        req = r; we = w; addr = a; wdata = d; run = rn; retire = rt;
        #1;
        if (r) begin
            check({tag, " flag"}, {31'd0, illegal}, {31'd0, ~model_legal(a)});
            if (!w || !model_legal(a)) check({tag, " read"}, rdata, model_read(a));
        end else begin
            check({tag, " R10 idle flag"}, {31'd0, illegal}, 32'd0);
        end
        cyc_w  = r && w && (a == A_CL || a == A_CH);
        ret_w  = r && w && (a == A_RL || a == A_RH);
        cyc_go = rn && !m_inh[0] && !cyc_w;
        ret_go = rt && !m_inh[2] && !ret_w;
        if (r && w) begin
            case (a)
                A_CL:  m_cyc[31:0]  = d;
                A_CH:  m_cyc[63:32] = d;
                A_RL:  m_ret[31:0]  = d;
                A_RH:  m_ret[63:32] = d;
                A_INH: m_inh = {d[2], 1'b0, d[0]};
                default: ;
            endcase
        end
        if (cyc_go) m_cyc = m_cyc + 64'd1;
        if (ret_go) m_ret = m_ret + 64'd1;
    endtask

    task automatic rd(input logic [11:0] a, input logic rn, input logic rt, input string tag);
        step(1'b1, 1'b0, a, 32'd0, rn, rt, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic rn,
                      input logic rt, input string tag);
        step(1'b1, 1'b1, a, d, rn, rt, tag);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run = 0; retire = 0; req = 0; we = 0; addr = '0; wdata = '0;
        m_cyc = '0; m_ret = '0; m_inh = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state through every register
        rd(A_CL, 0, 0, "R4");
        rd(A_CH, 0, 0, "R4");
        rd(A_RL, 0, 0, "R4");
        rd(A_RH, 0, 0, "R4");
        rd(A_INH, 0, 0, "R4");
        step(0, 0, A_CL, 0, 0, 0, "R4");

        // R1: counting while running, holding when not
        for (int i = 0; i < 10; i++) rd(A_CL, 1, 0, "R1");
        for (int i = 0; i < 4; i++)  rd(A_CL, 0, 0, "R1 hold");
        for (int i = 0; i < 6; i++)  rd(A_CL, i % 2, 0, "R1 gap");

        // R2: retirement pulses in a sparse pattern
        for (int i = 0; i < 12; i++) rd(A_RL, 1, (i % 3) == 0, "R2");

        // R3: high words and inhibit readback
        rd(A_CH, 1, 1, "R3");
        rd(A_RH, 1, 1, "R3");
        rd(A_INH, 1, 1, "R3");

        // R7 and R8: half writes with an increment pending
        wr(A_CH, 32'h1234_5678, 1, 1, "R7 R8");
        rd(A_CH, 0, 0, "R7");
        rd(A_CL, 0, 0, "R8");
        wr(A_RL, 32'h0000_0100, 1, 1, "R7 R8");
        rd(A_RL, 0, 0, "R8");
        rd(A_RH, 0, 0, "R7");

        // R9: carry from low word into high word
        wr(A_CL, 32'hFFFF_FFFE, 1, 0, "R9");
        rd(A_CL, 1, 0, "R9");
        rd(A_CL, 1, 0, "R9");
        rd(A_CL, 0, 0, "R9");
        rd(A_CH, 0, 0, "R9");
        wr(A_RL, 32'hFFFF_FFFF, 0, 0, "R9");
        wr(A_RH, 32'hFFFF_FFFF, 0, 0, "R9");
        rd(A_RL, 0, 1, "R9");
        rd(A_RL, 0, 0, "R9");
        rd(A_RH, 0, 0, "R9 wrap");

        // R6: only bits 0 and 2 kept
        wr(A_INH, 32'hFFFF_FFFF, 1, 1, "R6");
        rd(A_INH, 1, 1, "R6");
        rd(A_CL, 1, 1, "R6");
        wr(A_INH, 32'h0000_0002, 0, 0, "R6");
        rd(A_INH, 0, 0, "R6");

        // R5: each inhibit bit alone
        wr(A_INH, 32'h1, 1, 1, "R5");
        for (int i = 0; i < 8; i++) rd((i % 2) ? A_RL : A_CL, 1, 1, "R5 cycle stop");
        wr(A_INH, 32'h4, 1, 1, "R5");
        for (int i = 0; i < 8; i++) rd((i % 2) ? A_RL : A_CL, 1, 1, "R5 retire stop");
        wr(A_INH, 32'h0, 1, 1, "R5");
        rd(A_CL, 1, 1, "R5 resume");
        rd(A_RL, 1, 1, "R5 resume");

        // R10: unimplemented addresses, reads and writes
        rd(12'h000, 1, 1, "R10");
        rd(12'hB01, 1, 1, "R10");
        rd(12'hFFF, 1, 1, "R10");
        wr(12'hB03, 32'hDEAD_BEEF, 0, 0, "R10");
        wr(12'h321, 32'hFFFF_FFFF, 0, 0, "R10");
        rd(A_CL, 0, 0, "R10 no effect");
        rd(A_CH, 0, 0, "R10 no effect");
        rd(A_RL, 0, 0, "R10 no effect");
        rd(A_RH, 0, 0, "R10 no effect");
        rd(A_INH, 0, 0, "R10 no effect");

        // Mixed traffic compared on every cycle
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            case (i % 7)
                0: a = A_CL;  1: a = A_RL;  2: a = A_CH;  3: a = A_RH;
                4: a = A_INH; 5: a = 12'h7A5; default: a = A_CL;
            endcase
            if ((i % 23) == 5)       wr(A_INH, (i % 46 == 5) ? 32'h1 : 32'h0, i % 2, i % 3 == 0, "R5 mix");
            else if ((i % 31) == 9)  wr(A_CL, 32'hFFFF_FFF0 + i, 1, 1, "R9 mix");
            else if ((i % 37) == 11) wr(A_RH, i, 1, 1, "R7 mix");
            else                     step((i % 5) != 4, 1'b0, a, 32'd0, (i % 4) != 1, (i % 3) == 0, "R3 mix");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule